// File: doc/BRIEF.md
# Nonvolatile Setting Store Controller

This block sits beside the serial command decoder of a dual variable-resistor channel. It owns a sixteen-word, sixteen-bit nonvolatile store. Words 0 and 1 hold the saved settings for wiper channels 0 and 1, words 2 to 14 are free user constants, and word 15 is reserved. The physical cell is modelled as a register array. Each slow operation is given a fixed latency in system clock cycles. During that latency the block pulls its ready line low and raises a lock that stops the decoder from taking new frames.

The decoder presents one request per cycle as an opcode, an address and a data word. Save, user write, restore-all and the two reads are timed. A single-channel restore acts at once. The block loads the wiper registers through a pair of load strobes, each with its own value. It also watches an asynchronous active-low preset pin, which forces midscale while the pin is held low and reloads the saved settings when the pin is released. An active-low write-protect input blocks every change to the store.

Top module: `nv_store_ctrl`

## Requirements
- R1: After reset, words 0 and 1 hold 512 and words 2 to 15 hold 0. In the first cycle after reset, both load strobes fire with 512, and `rdy` is high from the next cycle.
- R2: Opcode 2 (save wiper) stores the low 10 bits of `req_data`, zero-extended, into word `req_addr[0]`. `rdy` stays low for exactly SAVE_CYC cycles, and the word takes its new value when `rdy` returns high.
- R3: Opcode 3 (user write) stores all 16 bits of `req_data` into word `req_addr` for addresses 0 to 14, with `rdy` low for SAVE_CYC cycles. A user write to address 15 is discarded, and `rdy` stays high.
- R4: Opcode 9 (read store) holds `rdy` low for READ_CYC cycles. When `rdy` returns high, `rd_valid` is high for exactly one cycle and `rd_data` equals word `req_addr`. Opcode 10 (read wiper) holds `rdy` low for READ_CYC cycles and pulses neither `rd_valid` nor the load strobes.
- R5: Opcode 8 (restore all) holds `rdy` low for RALL_CYC cycles. When `rdy` returns high, both load strobes fire with the low 10 bits of words 0 and 1.
- R6: Opcode 1 (restore one) fires only load strobe `req_addr[0]`, in the cycle after acceptance, with the low 10 bits of that word. `rdy` stays high. It sets `read_pwr`, which stays high until an opcode 0 request is accepted.
- R7: `preset_n` passes through a two-flop synchroniser. While the synchronised pin is low, both strobes fire every cycle with midscale 512 and `rdy` is low. One cycle after the synchronised rise, both strobes fire with the saved words. A preset aborts any operation in progress, and an aborted save leaves the store unchanged.
- R8: While `wp_n` is low when a request is accepted, opcodes 2 and 3 change no word and leave `rdy` high. Opcodes 1 and 8 and the preset pin still load the wipers.
- R9: A request presented while `rdy` is low is dropped and sets `overrun`, which stays high until reset.
- R10: `lock` is always the inverse of `rdy`. Opcodes 4 to 7 and 11 to 15 leave `rdy` high, fire no load strobe and do not pulse `rd_valid`.
- R11: A restore of a word written with 16 bits through opcode 3 loads only its low 10 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe from the decoder |
| req_op | input | 4 | Request opcode |
| req_addr | input | 4 | Store word address |
| req_data | input | 16 | Request data |
| wp_n | input | 1 | Active-low write protect |
| preset_n | input | 1 | Asynchronous active-low preset pin |
| ld_en | output | 2 | Per-channel wiper load strobes |
| ld_val0 | output | 10 | Load value, channel 0 |
| ld_val1 | output | 10 | Load value, channel 1 |
| rd_valid | output | 1 | One-cycle read result strobe |
| rd_data | output | 16 | Read result |
| rdy | output | 1 | Ready, low while an operation runs (open-drain style) |
| lock | output | 1 | Frame lock for the serial front end |
| read_pwr | output | 1 | Higher-power read state after a single restore |
| overrun | output | 1 | Sticky dropped-request flag |

## Verification
Several situations are hard to reach from the ports. The most difficult is a preset arriving in the middle of a save, because it must abort the write. The bench starts a long save and holds `preset_n` low a few cycles later. After release it reads the word back and confirms it kept its earlier value. Overrun is reached by presenting a second request in the cycle right after a save is accepted. The bench then confirms that the first save still lands and that no extra busy period follows. Write protect is shown to block stores by reading each target word back. It is shown to leave restores working by counting load strobes during restore-all and preset.

// File: rtl/nv_store_ctrl.sv
module nv_store_ctrl #(
  parameter int DW       = 16,
  parameter int WW       = 10,
  parameter int AW       = 4,
  parameter int SAVE_CYC = 40,
  parameter int RALL_CYC = 10,
  parameter int READ_CYC = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [3:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_data,
  input  logic          wp_n,
  input  logic          preset_n,
  output logic [1:0]    ld_en,
  output logic [WW-1:0] ld_val0,
  output logic [WW-1:0] ld_val1,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic          rdy,
  output logic          lock,
  output logic          read_pwr,
  output logic          overrun
);
  localparam int DEPTH = 1 << AW;
  localparam int RSV   = DEPTH - 1;
  localparam logic [WW-1:0] MID = WW'(1 << (WW - 1));
  localparam int MAXC  = (SAVE_CYC > RALL_CYC) ? ((SAVE_CYC > READ_CYC) ? SAVE_CYC : READ_CYC)
                                               : ((RALL_CYC > READ_CYC) ? RALL_CYC : READ_CYC);
  localparam int CW    = $clog2(MAXC + 1);

  localparam logic [3:0] OP_NOP = 4'd0, OP_RST1 = 4'd1, OP_SAVEW = 4'd2, OP_WUSER = 4'd3,
                         OP_RALL = 4'd8, OP_RDMEM = 4'd9, OP_RDWIP = 4'd10;

  logic [DW-1:0] mem [DEPTH];
  logic          ps1, ps2, ps_q, por_pend, busy;
  logic [CW-1:0] cnt;
  logic [3:0]    op_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;

  wire pre_low  = !ps2;
  wire pre_rise = ps2 && !ps_q;
  assign rdy  = !busy && ps2 && ps_q && !por_pend;
  assign lock = !rdy;
  wire acc      = req_valid && rdy;
  wire is_save  = acc && wp_n && (req_op == OP_SAVEW);
  wire is_wuser = acc && wp_n && (req_op == OP_WUSER) && (req_addr != AW'(RSV));
  wire is_timed = is_save || is_wuser ||
                  (acc && (req_op == OP_RALL || req_op == OP_RDMEM || req_op == OP_RDWIP));
  wire done     = busy && (cnt == '0);
  wire mem_we   = done && !pre_low && (op_q == OP_SAVEW || op_q == OP_WUSER);

  function automatic logic [CW-1:0] cyc_of(input logic [3:0] op);
    case (op)
      OP_SAVEW, OP_WUSER: cyc_of = CW'(SAVE_CYC - 1);
      OP_RALL:            cyc_of = CW'(RALL_CYC - 1);
      default:            cyc_of = CW'(READ_CYC - 1);
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) {ps1, ps2, ps_q} <= 3'b111;
    else        {ps1, ps2, ps_q} <= {preset_n, ps1, ps2};

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)                               mem[i] <= (i < 2) ? DW'(MID) : '0;
      else if (mem_we && addr_q == AW'(i))      mem[i] <= data_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; cnt <= '0; op_q <= OP_NOP; addr_q <= '0; data_q <= '0;
      por_pend <= 1'b1; ld_en <= 2'b00; ld_val0 <= MID; ld_val1 <= MID;
      rd_valid <= 1'b0; rd_data <= '0; read_pwr <= 1'b0; overrun <= 1'b0;
    end else begin
      ld_en    <= 2'b00;
      rd_valid <= 1'b0;
      por_pend <= 1'b0;
      if (req_valid && !rdy) overrun <= 1'b1;
      if (pre_low) begin
        busy <= 1'b0;
        ld_en <= 2'b11; ld_val0 <= MID; ld_val1 <= MID;
      end else begin
        if (pre_rise || por_pend || (done && op_q == OP_RALL)) begin
          ld_en <= 2'b11; ld_val0 <= mem[0][WW-1:0]; ld_val1 <= mem[1][WW-1:0];
        end
        if (done) begin
          busy <= 1'b0;
          if (op_q == OP_RDMEM) begin
            rd_valid <= 1'b1; rd_data <= mem[addr_q];
          end
        end else if (busy) cnt <= cnt - 1'b1;
        if (is_timed) begin
          busy <= 1'b1; cnt <= cyc_of(req_op); op_q <= req_op;
          addr_q <= (req_op == OP_SAVEW) ? AW'(req_addr[0]) : req_addr;
          data_q <= (req_op == OP_SAVEW) ? DW'(req_data[WW-1:0]) : req_data;
        end
        if (acc && req_op == OP_RST1) begin
          read_pwr <= 1'b1;
          if (req_addr[0]) begin ld_en <= 2'b10; ld_val1 <= mem[1][WW-1:0]; end
          else             begin ld_en <= 2'b01; ld_val0 <= mem[0][WW-1:0]; end
        end
        if (acc && req_op == OP_NOP) read_pwr <= 1'b0;
      end
    end
  end

  AST_PRESET_MID: assert property (@(posedge clk) disable iff (!rst_n)
    pre_low |=> (ld_en == 2'b11 && ld_val0 == MID && ld_val1 == MID)); // R7
  AST_SAVE_LOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && rdy && wp_n && req_op == OP_SAVEW) |=> lock); // R2
  AST_WP_NO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && rdy && !wp_n && ps1 && (req_op == OP_SAVEW || req_op == OP_WUSER)) |=> rdy); // R8
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun); // R9
  AST_RD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid); // R4
  AST_RSV_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(mem[RSV])); // R3
endmodule

// File: tb/nv_store_ctrl_bench.sv
`timescale 1ns/1ps
module nv_store_ctrl_bench;
  localparam int SC = 12, RC = 6, DC = 3;
  logic clk = 0, rst_n = 0, req_valid = 0, wp_n = 1, preset_n = 1;
  logic [3:0] req_op = 0, req_addr = 0;
  logic [15:0] req_data = 0;
  logic [1:0] ld_en;
  logic [9:0] ld_val0, ld_val1;
  logic rd_valid, rdy, lock, read_pwr, overrun;
  logic [15:0] rd_data;
  int tests = 0, fails = 0, ld_cnt = 0;
  logic [9:0] w0 = 0, w1 = 0;
  logic [15:0] exp_mem [16];

  always #2.5 clk = ~clk;

  nv_store_ctrl #(.SAVE_CYC(SC), .RALL_CYC(RC), .READ_CYC(DC)) u_nv_store_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr),
    .req_data(req_data), .wp_n(wp_n), .preset_n(preset_n), .ld_en(ld_en), .ld_val0(ld_val0),
    .ld_val1(ld_val1), .rd_valid(rd_valid), .rd_data(rd_data), .rdy(rdy), .lock(lock),
    .read_pwr(read_pwr), .overrun(overrun));

  always @(negedge clk) begin
    if (ld_en[0]) w0 = ld_val0;
    if (ld_en[1]) w1 = ld_val1;
    if (ld_en != 0) ld_cnt++;
  end

  task automatic chk(input string req, input longint act, input longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [3:0] op, input logic [3:0] a, input logic [15:0] d);
    @(negedge clk); req_valid = 1; req_op = op; req_addr = a; req_data = d;
    @(negedge clk); req_valid = 0;
  endtask

  task automatic busy_len(output int n);
    n = 0;
    while (!rdy && n < 2000) begin n++; @(negedge clk); end
  endtask

  task automatic rd_chk(input string req, input logic [3:0] a);
    int n;
    send(4'd9, a, 16'h0);
    busy_len(n);
    chk({req, " read busy"}, n, DC);
    chk({req, " rd_valid"}, rd_valid, 1);
    chk({req, " rd_data"}, rd_data, exp_mem[a]);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int n, c0;
    for (int i = 0; i < 16; i++) exp_mem[i] = (i < 2) ? 16'd512 : 16'd0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); @(negedge clk); #1;
    chk("R1 por wiper0", w0, 512);
    chk("R1 por wiper1", w1, 512);
    chk("R1 rdy", rdy, 1);
    chk("R9 overrun reset", overrun, 0);

    for (int a = 2; a < 15; a++) begin
      exp_mem[a] = 16'hA000 ^ (16'(a) * 16'h0111);
      send(4'd3, 4'(a), exp_mem[a]);
      busy_len(n);
      chk("R3 user write busy", n, SC);
    end
    send(4'd3, 4'd15, 16'hFFFF);
    chk("R3 reserved write no busy", rdy, 1);
    for (int a = 0; a < 16; a++) rd_chk("R4 R3 R1 sweep", 4'(a));

    send(4'd10, 4'd0, 16'h0);
    chk("R4 read wiper rd_valid", rd_valid, 0);
    c0 = ld_cnt;
    busy_len(n);
    chk("R4 read wiper busy", n, DC);
    chk("R4 read wiper rd_valid end", rd_valid, 0);
    @(negedge clk);
    chk("R4 read wiper no load", ld_cnt, c0);

    send(4'd2, 4'd0, 16'hFC37); busy_len(n);
    chk("R2 save busy", n, SC);
    exp_mem[0] = 16'h0037;
    send(4'd2, 4'd3, 16'h0155); busy_len(n);
    exp_mem[1] = 16'h0155;
    rd_chk("R2 save ch0", 4'd0);
    rd_chk("R2 save ch1 via addr bit0", 4'd1);

    send(4'd8, 4'd0, 16'h0); busy_len(n);
    chk("R5 restore-all busy", n, RC);
    @(negedge clk); #1;
    chk("R5 wiper0", w0, 10'h037);
    chk("R5 wiper1", w1, 10'h155);

    send(4'd3, 4'd0, 16'hABCD); busy_len(n);
    exp_mem[0] = 16'hABCD;
    send(4'd1, 4'd0, 16'h0);
    chk("R6 restore-one rdy high", rdy, 1);
    @(negedge clk); #1;
    chk("R11 R6 wiper0 low bits", w0, 10'h3CD);
    chk("R6 wiper1 unchanged", w1, 10'h155);
    chk("R6 read_pwr set", read_pwr, 1);
    send(4'd0, 4'd0, 16'h0);
    @(negedge clk);
    chk("R6 read_pwr cleared by nop", read_pwr, 0);

    wp_n = 0;
    send(4'd3, 4'd5, 16'h1234);
    chk("R8 wp user write no busy", rdy, 1);
    send(4'd2, 4'd1, 16'h0000);
    chk("R8 wp save no busy", rdy, 1);
    rd_chk("R8 wp word5 kept", 4'd5);
    rd_chk("R8 wp word1 kept", 4'd1);
    c0 = ld_cnt;
    send(4'd8, 4'd0, 16'h0); busy_len(n);
    chk("R8 wp restore-all busy", n, RC);
    @(negedge clk);
    chk("R8 wp restore-all loads", ld_cnt, c0 + 1);

    @(negedge clk); preset_n = 0;
    repeat (5) @(negedge clk); #1;
    chk("R7 preset wiper0 mid", w0, 512);
    chk("R7 preset wiper1 mid", w1, 512);
    chk("R7 preset rdy low", rdy, 0);
    chk("R10 lock inverse", lock, 1);
    @(negedge clk); preset_n = 1;
    repeat (5) @(negedge clk); #1;
    chk("R7 R8 preset reload wiper0", w0, 10'h3CD);
    chk("R7 preset reload wiper1", w1, 10'h155);
    chk("R7 rdy after preset", rdy, 1);
    wp_n = 1;

    send(4'd3, 4'd7, 16'h7777);
    repeat (3) @(negedge clk);
    preset_n = 0;
    repeat (4) @(negedge clk);
    preset_n = 1;
    repeat (SC + 4) @(negedge clk);
    rd_chk("R7 preset aborts save", 4'd7);

    chk("R9 overrun clear before", overrun, 0);
    @(negedge clk); req_valid = 1; req_op = 4'd3; req_addr = 4'd6; req_data = 16'h6A6A;
    @(negedge clk); req_op = 4'd9; req_addr = 4'd2;
    @(negedge clk); req_valid = 0;
    busy_len(n);
    chk("R9 busy not extended", n, SC - 1);
    chk("R9 dropped read no rd_valid", rd_valid, 0);
    chk("R9 overrun set", overrun, 1);
    exp_mem[6] = 16'h6A6A;
    rd_chk("R9 first write landed", 4'd6);
    chk("R9 overrun sticky", overrun, 1);

    for (int op = 4; op < 16; op++) begin
      if (op >= 8 && op <= 10) continue;
      c0 = ld_cnt;
      send(4'(op), 4'd0, 16'hFFFF);
      chk("R10 ignored opcode rdy", rdy, 1);
      @(negedge clk);
      chk("R10 ignored opcode no load", ld_cnt, c0);
      chk("R10 ignored opcode no read", rd_valid, 0);
    end
    chk("R10 lock idle", lock, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule